// File: doc/BRIEF.md
# Buffered UART Transmitter with Break Frames and Selectable Interrupt Policy

This block is the transmit half of an asynchronous serial port. Software pushes 8-bit characters into a four-entry holding queue. A shift stage drains the queue and sends each character on a single output line. A character frame is one start bit, then eight data bits with the least significant bit first, then one stop bit. Bit timing comes from an external one-cycle `bitTick` strobe, so every bit lasts from one tick to the next. The block contains no baud generator.

Software can also request a break frame, which holds the line low for twelve bit times between a start bit and a stop bit. The break request clears itself once the break frame has gone out. The resting level of the line can be inverted. Which setting of the invert control means "rest low" depends on whether a downstream pulse encoder is enabled. A single-cycle interrupt pulse fires on one of three selectable events. Status outputs report a full queue, a completely idle transmitter, a pending break and a sticky overflow.

Top module: `txSerializer`

## Requirements
- R1: A frame starts on a `bitTick` cycle in which the shifter is idle, or in which it is finishing a stop bit. The line then shows logical 0 (start), then data bits 0 to 7, then logical 1 (stop). Each bit changes on the clock edge of a `bitTick` cycle, and the frame ends on the tick after the stop bit.
- R2: The idle level is `~idleInvert` when `encoderOn`=0 and `idleInvert` when `encoderOn`=1. `txOut` shows the logical bit unchanged when the idle level is 1 and complemented when it is 0. The line rests at the idle level whenever nothing is being sent.
- R3: The queue holds 4 characters and `bufFull` is 1 exactly when it holds 4. A write (`wrValid`) while the queue is full is dropped and sets `overflow`. `overflow` stays set until a cycle with `ovfClear`=1, and a new overflow in that same cycle wins.
- R4: `shiftEmpty` is 1 after reset. It is 1 exactly when the shifter is idle and the queue is empty, and 0 while a frame is in progress or queued.
- R5: A `breakSet` pulse sets `breakPending`. The next frame is then a start bit, twelve logical 0 bits and a stop bit (14 bit times), and it takes priority over queued characters. A request made during a character frame waits for that frame's stop bit. `breakPending` clears when the break frame ends, and queued characters follow it.
- R6: While `txEnable`=0, any frame is aborted, the queue is emptied, `breakPending` is cleared and `txOut` holds the idle level. Writes and `breakSet` are ignored while disabled.
- R7: With `irqMode`=00, an interrupt fires whenever a character moves from the queue into the shifter. Loading a break frame does not count as such a move.
- R8: With `irqMode`=10, an interrupt fires when a character moves into the shifter and this leaves the queue empty.
- R9: With `irqMode`=01, an interrupt fires when a frame ends and nothing further is queued or pending, so that the transmitter goes fully idle.
- R10: `irqMode`=11 never raises an interrupt. `irqPulse` is high for one cycle, in the cycle after the clock edge of the event. The mode in force at the event decides whether it fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Transmit enable; low aborts and flushes |
| bitTick | input | 1 | One-cycle bit-rate strobe |
| encoderOn | input | 1 | Downstream encoder enabled; selects idle-level sense |
| idleInvert | input | 1 | Idle-level invert control |
| irqMode | input | 2 | Interrupt policy select |
| wrValid | input | 1 | Write a character into the queue |
| wrData | input | 8 | Character to write |
| breakSet | input | 1 | Request a break frame |
| ovfClear | input | 1 | Clear the overflow flag |
| txOut | output | 1 | Serial line |
| irqPulse | output | 1 | Single-cycle transmit interrupt |
| bufFull | output | 1 | Queue cannot accept another character |
| shiftEmpty | output | 1 | Shifter and queue both empty |
| breakPending | output | 1 | Break request outstanding |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bound checker watches these rules on every cycle:
- a disabled transmitter always ends up idle and flushed, with the line at the correct resting level;
- a write to a full queue always flags overflow, and the flag persists until it is cleared;
- a full queue never coexists with an empty indication;
- the reserved interrupt mode stays silent, and interrupt pulses never last two cycles.

Some behaviour can only be shown by the bench's scenarios, which follow exact bit sequences:
- frame contents under all four polarity settings;
- the 14-bit break shape, and that it waits behind a character already being sent;
- which specific event each interrupt mode reacts to;
- that dropped or disabled-time writes never appear on the line.

// File: rtl/txPkg.sv
`timescale 1ns/1ps
package txPkg;
  // Strobes the control half issues to the datapath half each cycle.
  typedef struct packed {
    logic push;       // store wrData at the queue tail
    logic loadChar;   // move queue head into the shifter as a character frame
    logic loadBreak;  // load a break frame into the shifter
    logic shift;      // advance the shifter by one bit
    logic flush;      // empty the queue and park the shifter at idle
  } txStrobe_t;
endpackage

// File: rtl/txCtrl.sv
`timescale 1ns/1ps
module txCtrl #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 4,
  parameter int BREAK_ZEROS = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             bitTick,
  input  logic [1:0]       irqMode,
  input  logic             wrValid,
  input  logic             breakSet,
  input  logic             ovfClear,
  output txPkg::txStrobe_t strobe,
  output logic             irqPulse,
  output logic             bufFull,
  output logic             shiftEmpty,
  output logic             breakPending,
  output logic             overflow
);
  localparam int CHAR_BITS  = DATA_W + 2;
  localparam int BREAK_BITS = BREAK_ZEROS + 2;
  localparam int MAX_BITS   = (BREAK_BITS > CHAR_BITS) ? BREAK_BITS : CHAR_BITS;
  localparam int CNT_W      = $clog2(MAX_BITS + 1);
  localparam int LVL_W      = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] level, levelNext;
  logic [CNT_W-1:0] bitsLeft;
  logic busy, isBreak, brkReq, ovf, irq;
  logic accept, frameEnd, slotFree, loadChar, loadBreak, irqEvent;

  always_comb begin
    accept    = txEnable && wrValid && (level != LVL_W'(DEPTH));
    frameEnd  = busy && bitTick && (bitsLeft == CNT_W'(1));
    slotFree  = bitTick && (!busy || frameEnd);
    loadBreak = txEnable && slotFree && brkReq && !(frameEnd && isBreak);
    loadChar  = txEnable && slotFree && !loadBreak && (level != '0);
    levelNext = level + LVL_W'(accept) - LVL_W'(loadChar);
    unique case (irqMode)
      2'b00:   irqEvent = loadChar;
      2'b10:   irqEvent = loadChar && (levelNext == '0);
      2'b01:   irqEvent = frameEnd && !loadChar && !loadBreak && (levelNext == '0);
      default: irqEvent = 1'b0;
    endcase
  end

  always_comb begin
    strobe.push      = accept;
    strobe.loadChar  = loadChar;
    strobe.loadBreak = loadBreak;
    strobe.shift     = txEnable && busy && bitTick;
    strobe.flush     = !txEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level    <= '0;
      bitsLeft <= '0;
      busy     <= 1'b0;
      isBreak  <= 1'b0;
      brkReq   <= 1'b0;
      ovf      <= 1'b0;
      irq      <= 1'b0;
    end else if (!txEnable) begin
      level    <= '0;
      bitsLeft <= '0;
      busy     <= 1'b0;
      isBreak  <= 1'b0;
      brkReq   <= 1'b0;
      ovf      <= ovf && !ovfClear;
      irq      <= 1'b0;
    end else begin
      level <= levelNext;
      if (loadBreak) begin
        busy     <= 1'b1;
        isBreak  <= 1'b1;
        bitsLeft <= CNT_W'(BREAK_BITS);
      end else if (loadChar) begin
        busy     <= 1'b1;
        isBreak  <= 1'b0;
        bitsLeft <= CNT_W'(CHAR_BITS);
      end else if (frameEnd) begin
        busy     <= 1'b0;
        isBreak  <= 1'b0;
        bitsLeft <= '0;
      end else if (busy && bitTick) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
      end
      brkReq <= (brkReq && !(frameEnd && isBreak)) || breakSet;
      ovf    <= (ovf && !ovfClear) || (wrValid && (level == LVL_W'(DEPTH)));
      irq    <= irqEvent;
    end
  end

  assign irqPulse     = irq;
  assign bufFull      = (level == LVL_W'(DEPTH));
  assign shiftEmpty   = !busy && (level == '0);
  assign breakPending = brkReq;
  assign overflow     = ovf;
endmodule

// File: rtl/txData.sv
`timescale 1ns/1ps
module txData #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 4,
  parameter int BREAK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  txPkg::txStrobe_t  strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              encoderOn,
  input  logic              idleInvert,
  output logic              txOut
);
  localparam int CHAR_BITS  = DATA_W + 2;
  localparam int BREAK_BITS = BREAK_ZEROS + 2;
  localparam int SR_W       = (BREAK_BITS > CHAR_BITS) ? BREAK_BITS : CHAR_BITS;
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [SR_W-1:0]   shreg;
  logic              idleLevel;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) slots[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      shreg <= '1;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      shreg <= '1;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.loadChar) begin
        rdPtr <= bump(rdPtr);
        shreg <= '1;
        shreg[CHAR_BITS-1:0] <= {1'b1, slots[rdPtr], 1'b0};
      end else if (strobe.loadBreak) begin
        shreg <= '1;
        shreg[BREAK_BITS-2:0] <= '0;
      end else if (strobe.shift) begin
        shreg <= {1'b1, shreg[SR_W-1:1]};
      end
    end
  end

  // Resting-level sense flips when the downstream encoder is active.
  assign idleLevel = encoderOn ? idleInvert : !idleInvert;
  assign txOut     = idleLevel ? shreg[0] : !shreg[0];
endmodule

// File: rtl/txSerializer.sv
`timescale 1ns/1ps
module txSerializer #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 4,
  parameter int BREAK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              bitTick,
  input  logic              encoderOn,
  input  logic              idleInvert,
  input  logic [1:0]        irqMode,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              breakSet,
  input  logic              ovfClear,
  output logic              txOut,
  output logic              irqPulse,
  output logic              bufFull,
  output logic              shiftEmpty,
  output logic              breakPending,
  output logic              overflow
);
  txPkg::txStrobe_t strobe;

  txCtrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BREAK_ZEROS(BREAK_ZEROS)) i_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .bitTick(bitTick),
    .irqMode(irqMode), .wrValid(wrValid), .breakSet(breakSet), .ovfClear(ovfClear),
    .strobe(strobe), .irqPulse(irqPulse), .bufFull(bufFull), .shiftEmpty(shiftEmpty),
    .breakPending(breakPending), .overflow(overflow)
  );

  txData #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BREAK_ZEROS(BREAK_ZEROS)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .encoderOn(encoderOn), .idleInvert(idleInvert), .txOut(txOut)
  );
endmodule

// File: rtl/txSerializerChecks.sv
`timescale 1ns/1ps
module txSerializerChecks (
  input logic       clk,
  input logic       rstN,
  input logic       txEnable,
  input logic       encoderOn,
  input logic       idleInvert,
  input logic [1:0] irqMode,
  input logic       wrValid,
  input logic       ovfClear,
  input logic       txOut,
  input logic       irqPulse,
  input logic       bufFull,
  input logic       shiftEmpty,
  input logic       breakPending,
  input logic       overflow
);
  a_r3_full_write_flags: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && wrValid && bufFull) |=> overflow);
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClear) |=> overflow);
  a_r4_full_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> !shiftEmpty);
  a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (txOut == (encoderOn ? idleInvert : !idleInvert)));
  a_r6_disabled_flush: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (shiftEmpty && !bufFull && !breakPending));
  a_r10_reserved_silent: assert property (@(posedge clk) disable iff (!rstN)
    (irqMode == 2'b11) |=> !irqPulse);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
endmodule

bind txSerializer txSerializerChecks i_checks (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .encoderOn(encoderOn),
  .idleInvert(idleInvert), .irqMode(irqMode), .wrValid(wrValid), .ovfClear(ovfClear),
  .txOut(txOut), .irqPulse(irqPulse), .bufFull(bufFull), .shiftEmpty(shiftEmpty),
  .breakPending(breakPending), .overflow(overflow)
);

// File: tb/test_txSerializer.sv
`timescale 1ns/1ps
module test_txSerializer;
  logic clk = 1'b0, rstN = 1'b0, txEnable = 1'b0, bitTick = 1'b0;
  logic encoderOn = 1'b0, idleInvert = 1'b0, wrValid = 1'b0, breakSet = 1'b0, ovfClear = 1'b0;
  logic [1:0] irqMode = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic txOut, irqPulse, bufFull, shiftEmpty, breakPending, overflow;

  int nChecks = 0, nFails = 0;
  logic curIdle = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txSerializer i_txSerializer (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .bitTick(bitTick),
    .encoderOn(encoderOn), .idleInvert(idleInvert), .irqMode(irqMode),
    .wrValid(wrValid), .wrData(wrData), .breakSet(breakSet), .ovfClear(ovfClear),
    .txOut(txOut), .irqPulse(irqPulse), .bufFull(bufFull), .shiftEmpty(shiftEmpty),
    .breakPending(breakPending), .overflow(overflow)
  );

  // {expected idle level, encoderOn, idleInvert, character}
  localparam logic [10:0] VECS [4] = '{
    {1'b1, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b0, 1'b1, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'h81},
    {1'b1, 1'b1, 1'b1, 8'h5E}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic lineOf(input logic v);
    return curIdle ? v : !v;
  endfunction

  task automatic tick();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin wrValid = 1'b1; wrData = d; end
    @(negedge clk) wrValid = 1'b0;
  endtask

  task automatic pulseBreak();
    @(negedge clk) breakSet = 1'b1;
    @(negedge clk) breakSet = 1'b0;
  endtask

  // Ten ticks of a character frame; the first tick loads it.
  task automatic sendChar(input logic [7:0] d, input bit brkMid,
                          output logic firstIrq, output logic laterIrq);
    laterIrq = 1'b0;
    tick();
    firstIrq = irqPulse;
    chk("R1 start bit", txOut, lineOf(1'b0));
    if (brkMid) begin
      breakSet = 1'b1;
      @(negedge clk) breakSet = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      tick();
      laterIrq |= irqPulse;
      chk("R1 data bit", txOut, lineOf(d[i]));
    end
    tick();
    laterIrq |= irqPulse;
    chk("R1 stop bit", txOut, lineOf(1'b1));
  endtask

  task automatic sendBreak(output logic firstIrq);
    tick();
    firstIrq = irqPulse;
    chk("R5 break start", txOut, lineOf(1'b0));
    for (int i = 0; i < 12; i++) begin
      tick();
      chk("R5 break zero", txOut, lineOf(1'b0));
    end
    tick();
    chk("R5 break stop", txOut, lineOf(1'b1));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic fi, li;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R4 reset shiftEmpty", shiftEmpty, 1);
    chk("R3 reset bufFull", bufFull, 0);
    chk("R3 reset overflow", overflow, 0);
    chk("R2 reset idle line", txOut, 1);
    chk("R10 reset irq", irqPulse, 0);
    chk("R5 reset breakPending", breakPending, 0);

    // Table walk: polarity settings, one character each, mode 00.
    txEnable = 1'b1;
    irqMode = 2'b00;
    for (int v = 0; v < 4; v++) begin
      @(negedge clk) begin encoderOn = VECS[v][9]; idleInvert = VECS[v][8]; end
      @(negedge clk);
      curIdle = VECS[v][10];
      chk("R2 idle level", txOut, VECS[v][10]);
      wr(VECS[v][7:0]);
      chk("R4 queued not empty", shiftEmpty, 0);
      sendChar(VECS[v][7:0], 1'b0, fi, li);
      chk("R7 irq on load", fi, 1);
      chk("R10 pulse single", li, 0);
      tick();
      chk("R7 no irq at frame end", irqPulse, 0);
      chk("R4 empty after frame", shiftEmpty, 1);
      chk("R2 back to idle", txOut, VECS[v][10]);
    end
    @(negedge clk) begin encoderOn = 1'b0; idleInvert = 1'b0; end
    curIdle = 1'b1;

    // Fill, overflow, mode 10 then mode 01.
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    chk("R3 full at four", bufFull, 1);
    chk("R4 not empty when full", shiftEmpty, 0);
    wr(8'h99);
    chk("R3 overflow set", overflow, 1);
    chk("R3 still full", bufFull, 1);
    @(negedge clk) ovfClear = 1'b1;
    @(negedge clk) ovfClear = 1'b0;
    chk("R3 overflow cleared", overflow, 0);
    irqMode = 2'b10;
    sendChar(8'h11, 1'b0, fi, li);
    chk("R8 no irq while queue nonempty", fi, 0);
    chk("R3 slot freed", bufFull, 0);
    sendChar(8'h22, 1'b0, fi, li);
    chk("R8 no irq second", fi, 0);
    sendChar(8'h33, 1'b0, fi, li);
    chk("R8 no irq third", fi, 0);
    sendChar(8'h44, 1'b0, fi, li);
    chk("R8 irq when queue drains", fi, 1);
    irqMode = 2'b01;
    tick();
    chk("R9 irq on completion", irqPulse, 1);
    chk("R4 empty on completion", shiftEmpty, 1);
    tick();
    chk("R3 dropped write never sent", txOut, 1);
    chk("R3 dropped write not queued", shiftEmpty, 1);

    // Break from idle, then break requested mid-frame.
    irqMode = 2'b00;
    pulseBreak();
    chk("R5 pending set", breakPending, 1);
    sendBreak(fi);
    chk("R7 break load no irq", fi, 0);
    tick();
    chk("R5 pending cleared", breakPending, 0);
    chk("R5 idle after break", shiftEmpty, 1);
    wr(8'h5A); wr(8'hC3);
    sendChar(8'h5A, 1'b1, fi, li);
    chk("R5 pending during frame", breakPending, 1);
    sendBreak(fi);
    sendChar(8'hC3, 1'b0, fi, li);
    chk("R5 char after break irq", fi, 1);
    chk("R5 pending cleared after", breakPending, 0);
    tick();
    chk("R5 all done", shiftEmpty, 1);

    // Abort on disable.
    wr(8'hF0); wr(8'h0F);
    tick(); tick(); tick();
    @(negedge clk) txEnable = 1'b0;
    @(negedge clk);
    chk("R6 line idle when disabled", txOut, 1);
    chk("R6 flushed empty", shiftEmpty, 1);
    chk("R6 flushed not full", bufFull, 0);
    wr(8'h77);
    pulseBreak();
    chk("R6 break ignored", breakPending, 0);
    @(negedge clk) txEnable = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick();
      chk("R6 nothing resumes", txOut, 1);
    end
    chk("R6 still empty", shiftEmpty, 1);

    // Reserved mode.
    irqMode = 2'b11;
    wr(8'h3F);
    sendChar(8'h3F, 1'b0, fi, li);
    chk("R10 reserved no load irq", fi, 0);
    tick();
    chk("R10 reserved no end irq", irqPulse, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule